// File: doc/BRIEF.md
# Two-of-Seven Transition-Coded Link Codec

This block carries packets between two chips over eight wires: seven data wires and one acknowledge. Every 4-bit symbol is sent by flipping exactly two of the seven data wires. The receiving side answers by flipping the acknowledge wire. No wire ever returns to a rest level, so one symbol costs one data transition phase and one acknowledge phase. Of the 21 ways to choose two wires from seven, 16 carry a nibble and one marks the end of a packet. The other four are treated as line errors.

On the chip side, packets travel as 1-of-5 flits. A flit is either one of four one-hot data lines, each carrying a 2-bit value, or an end-of-packet line. The transmitter joins two successive data flits into one nibble and launches the matching wire pair. It then waits for the acknowledge before launching again. The receiver registers the incoming wire levels and compares them with a stored reference. When exactly two wires differ, it decodes the symbol, flips the acknowledge, and splits the nibble back into flits. The two link directions are exposed as separate ports, so the transmitter of one chip drives the receiver of another. Wire levels are modelled as registered logic.

Top module: `nrz27_link`

## Requirements
- R1: After reset, the seven transmit wires and the receive acknowledge are low, no output flit is valid, and the transmitter accepts a data flit.
- R2: Every change of the transmit wires flips exactly two wires. The flipped pair (i<j) gives the symbol index by lexicographic pair order: (0,1)=0, (0,2)=1, …, (0,6)=5, (1,2)=6, …, (5,6)=20. Index 0..15 is a nibble and 16 is end-of-packet.
- R3: On-chip flits use bit k (k=0..3) for data value k and bit 4 for end-of-packet. The first data flit of a pair forms nibble bits [1:0] and the second forms bits [3:2].
- R4: An end-of-packet flit that arrives while one data flit is unpaired first causes a symbol carrying that flit with zero in bits [3:2], and then the end-of-packet symbol.
- R5: Once a symbol is launched, the transmit wires stay unchanged until an acknowledge transition is seen.
- R6: An acknowledge pulse lasting a single clock cycle is ignored.
- R7: An acknowledge transition that arrives while no symbol is outstanding is absorbed. It neither launches nor releases a symbol.
- R8: When exactly two receive wires differ from the reference and the pair is legal, the receiver flips its acknowledge once. It then outputs the flits in order: low 2-bit field first, then the high field; end-of-packet gives the single flit with bit 4 set.
- R9: A legal-weight pair with index 17..20 pulses the code-error output, adopts the new levels as the reference, flips the acknowledge, and produces no flit.
- R10: More than two changed wires in one sample pulse the code-error output, adopt the new reference, flip the acknowledge, and produce no flit.
- R11: While an output flit is not taken, it stays valid and unchanged, and no further symbol is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tx_in_vld | input | 1 | On-chip flit offered to the transmitter |
| tx_in_flit | input | 5 | 1-of-5 flit: bits 3..0 data value, bit 4 end-of-packet |
| tx_in_rdy | output | 1 | Transmitter takes the flit this cycle |
| lnk_tx_wires | output | 7 | Transmit data wire levels |
| lnk_tx_ack | input | 1 | Acknowledge returned by the far receiver |
| lnk_rx_wires | input | 7 | Receive data wire levels |
| lnk_rx_ack | output | 1 | Acknowledge driven back to the far transmitter |
| rx_out_vld | output | 1 | Output flit valid |
| rx_out_flit | output | 5 | 1-of-5 output flit |
| rx_out_rdy | input | 1 | Consumer takes the output flit |
| rx_code_err | output | 1 | One-cycle pulse on an illegal or over-weight change |

## Verification
The transmitter can see a stale acknowledge transition in the same cycle that it launches a new symbol. If it counted that transition as the new symbol's acknowledge, it would launch again without one. The bench provokes this in two ways. It permanently inverts the acknowledge polarity while the link is idle. It also injects one-cycle acknowledge pulses at random points during random packet traffic, including cycles where a pair completes. A wire monitor decodes every launch and compares it with the symbol sequence expected from the flits offered. The bench also checks that stalled traffic launches exactly two symbols before it stops.

// File: rtl/nrz27_pkg.sv
package nrz27_pkg;
  localparam int NWIRE   = 7;
  localparam int IDX_W   = 5;
  localparam int FLIT_W  = 5;
  localparam int EOP_IDX = 16;

  typedef logic [NWIRE-1:0]  wire_t;
  typedef logic [IDX_W-1:0]  sym_t;
  typedef logic [FLIT_W-1:0] flit_t;

  localparam sym_t  SYM_EOP  = sym_t'(EOP_IDX);
  localparam sym_t  SYM_BAD  = '1;
  localparam flit_t FLIT_EOP = flit_t'(1) << 4;

  // symbol index -> two-hot wire pattern, lexicographic pair order
  function automatic wire_t sym_to_code(sym_t s);
    wire_t c = '0;
    int k = 0;
    for (int i = 0; i < NWIRE - 1; i++)
      for (int j = i + 1; j < NWIRE; j++) begin
        if (k == int'(s)) begin
          c[i] = 1'b1;
          c[j] = 1'b1;
        end
        k++;
      end
    return c;
  endfunction

  // two-hot pattern -> symbol index (0..20), SYM_BAD when not two-hot
  function automatic sym_t code_to_sym(wire_t c);
    sym_t r = SYM_BAD;
    int k = 0;
    for (int i = 0; i < NWIRE - 1; i++)
      for (int j = i + 1; j < NWIRE; j++) begin
        wire_t p;
        p = '0;
        p[i] = 1'b1;
        p[j] = 1'b1;
        if (c == p) r = sym_t'(k);
        k++;
      end
    return r;
  endfunction

  function automatic flit_t data_flit(logic [1:0] v);
    return flit_t'(1) << v;
  endfunction

  function automatic logic [1:0] flit_val(flit_t f);
    logic [1:0] v = 2'd0;
    for (int b = 3; b >= 0; b--)
      if (f[b]) v = 2'(b);
    return v;
  endfunction
endpackage

// File: rtl/nrz27_tx_pair.sv
module nrz27_tx_pair
  import nrz27_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  in_vld,
  input  flit_t in_flit,
  output logic  in_rdy,
  input  logic  line_busy,
  output logic  sym_vld,
  output sym_t  sym_idx
);
  logic       have_half;
  logic [1:0] half;
  logic       in_eop, take, pad_fire;

  assign in_eop = in_flit[4];

  always_comb begin
    if (have_half) in_rdy = !line_busy && !in_eop;
    else           in_rdy = in_eop ? !line_busy : 1'b1;
  end

  assign take     = in_vld && in_rdy;
  assign pad_fire = in_vld && have_half && in_eop && !line_busy;
  assign sym_vld  = pad_fire || (take && (in_eop || have_half));

  always_comb begin
    if (pad_fire)    sym_idx = {1'b0, 2'b00, half};
    else if (in_eop) sym_idx = SYM_EOP;
    else             sym_idx = {1'b0, flit_val(in_flit), half};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_half <= 1'b0;
      half      <= 2'd0;
    end else if (pad_fire) begin
      have_half <= 1'b0;
    end else if (take && !in_eop) begin
      if (have_half) have_half <= 1'b0;
      else begin
        have_half <= 1'b1;
        half      <= flit_val(in_flit);
      end
    end
  end
endmodule

// File: rtl/nrz27_tx_line.sv
module nrz27_tx_line
  import nrz27_pkg::*;
#(
  parameter int ACK_SYNC = 2
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  sym_vld,
  input  sym_t  sym_idx,
  output logic  busy,
  output wire_t wires_out,
  input  logic  ack_in
);
  localparam int LAST = ACK_SYNC - 1;

  logic [ACK_SYNC-1:0] ack_sh;
  logic  ack_filt, ack_seen, ack_evt, launch;
  wire_t lvl;

  assign ack_evt   = ack_filt != ack_seen;
  assign launch    = sym_vld && !busy;
  assign wires_out = lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_sh   <= '0;
      ack_filt <= 1'b0;
      ack_seen <= 1'b0;
      busy     <= 1'b0;
      lvl      <= '0;
    end else begin
      ack_sh <= {ack_sh[LAST-1:0], ack_in};
      if (ack_sh[LAST] == ack_sh[LAST-1]) ack_filt <= ack_sh[LAST];
      ack_seen <= ack_filt;
      if (launch) begin
        lvl  <= lvl ^ sym_to_code(sym_idx);
        busy <= 1'b1;
      end else if (ack_evt && busy) begin
        busy <= 1'b0;
      end
    end
  end

  // R2
  two_wire_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl != $past(lvl)) |-> ($countones(lvl ^ $past(lvl)) == 2 &&
                             code_to_sym(lvl ^ $past(lvl)) <= SYM_EOP));
  // R5
  hold_until_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ack_evt) |=> $stable(lvl));
  // R7
  idle_ack_absorb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && ack_evt && !sym_vld) |=> (!busy && $stable(lvl)));
endmodule

// File: rtl/nrz27_rx_line.sv
module nrz27_rx_line
  import nrz27_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  wire_t wires_in,
  output logic  ack_out,
  input  logic  slot_free,
  output logic  sym_vld,
  output sym_t  sym_idx,
  output logic  code_err
);
  wire_t rx_q, ref_lvl, diff;
  logic [2:0] cnt;
  logic complete, legal, resync;

  assign diff     = rx_q ^ ref_lvl;
  assign cnt      = 3'($countones(diff));
  assign sym_idx  = code_to_sym(diff);
  assign complete = cnt == 3'd2;
  assign legal    = sym_idx <= SYM_EOP;
  assign sym_vld  = complete && legal && slot_free;
  assign resync   = (complete && !legal) || cnt > 3'd2;
  assign code_err = resync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q    <= '0;
      ref_lvl <= '0;
      ack_out <= 1'b0;
    end else begin
      rx_q <= wires_in;
      if (sym_vld || resync) begin
        ref_lvl <= rx_q;
        ack_out <= !ack_out;
      end
    end
  end

  // R8
  ack_per_symbol_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sym_vld |=> (ack_out != $past(ack_out)));
endmodule

// File: rtl/nrz27_rx_split.sv
module nrz27_rx_split
  import nrz27_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  sym_vld,
  input  sym_t  sym_idx,
  output logic  slot_free,
  output logic  out_vld,
  output flit_t out_flit,
  input  logic  out_rdy
);
  logic pend, phase;
  sym_t idx;

  assign slot_free = !pend;
  assign out_vld   = pend;
  assign out_flit  = (idx == SYM_EOP) ? FLIT_EOP
                   : data_flit(phase ? idx[3:2] : idx[1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend  <= 1'b0;
      phase <= 1'b0;
      idx   <= '0;
    end else if (sym_vld && !pend) begin
      pend  <= 1'b1;
      phase <= 1'b0;
      idx   <= sym_idx;
    end else if (pend && out_rdy) begin
      if (idx == SYM_EOP || phase) pend <= 1'b0;
      else phase <= 1'b1;
    end
  end

  // R11
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && !out_rdy) |=> (out_vld && $stable(out_flit)));
endmodule

// File: rtl/nrz27_link.sv
module nrz27_link
  import nrz27_pkg::*;
#(
  parameter int ACK_SYNC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_in_vld,
  input  logic [4:0] tx_in_flit,
  output logic       tx_in_rdy,
  output logic [6:0] lnk_tx_wires,
  input  logic       lnk_tx_ack,
  input  logic [6:0] lnk_rx_wires,
  output logic       lnk_rx_ack,
  output logic       rx_out_vld,
  output logic [4:0] rx_out_flit,
  input  logic       rx_out_rdy,
  output logic       rx_code_err
);
  logic tx_busy, tx_sym_vld, rx_sym_vld, rx_slot_free;
  sym_t tx_sym_idx, rx_sym_idx;

  nrz27_tx_pair u_pair (
    .clk(clk), .rst_n(rst_n), .in_vld(tx_in_vld), .in_flit(tx_in_flit),
    .in_rdy(tx_in_rdy), .line_busy(tx_busy), .sym_vld(tx_sym_vld),
    .sym_idx(tx_sym_idx));

  nrz27_tx_line #(.ACK_SYNC(ACK_SYNC)) u_txl (
    .clk(clk), .rst_n(rst_n), .sym_vld(tx_sym_vld), .sym_idx(tx_sym_idx),
    .busy(tx_busy), .wires_out(lnk_tx_wires), .ack_in(lnk_tx_ack));

  nrz27_rx_line u_rxl (
    .clk(clk), .rst_n(rst_n), .wires_in(lnk_rx_wires), .ack_out(lnk_rx_ack),
    .slot_free(rx_slot_free), .sym_vld(rx_sym_vld), .sym_idx(rx_sym_idx),
    .code_err(rx_code_err));

  nrz27_rx_split u_split (
    .clk(clk), .rst_n(rst_n), .sym_vld(rx_sym_vld), .sym_idx(rx_sym_idx),
    .slot_free(rx_slot_free), .out_vld(rx_out_vld), .out_flit(rx_out_flit),
    .out_rdy(rx_out_rdy));
endmodule

// File: tb/sim_nrz27_link.sv
`timescale 1ns/1ps
module sim_nrz27_link;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tx_in_vld = 1'b0, rx_out_rdy = 1'b1;
  logic [4:0] tx_in_flit = 5'd0;
  logic ack_glitch = 1'b0, ack_inv = 1'b0, glitch_en = 1'b0;
  logic [6:0] wire_mask = 7'd0;
  logic tx_in_rdy, lnk_rx_ack, rx_out_vld, rx_code_err;
  logic [6:0] lnk_tx_wires;
  logic [4:0] rx_out_flit;

  always #4 clk = ~clk;

  nrz27_link u0 (
    .clk(clk), .rst_n(rst_n), .tx_in_vld(tx_in_vld), .tx_in_flit(tx_in_flit),
    .tx_in_rdy(tx_in_rdy), .lnk_tx_wires(lnk_tx_wires),
    .lnk_tx_ack(lnk_rx_ack ^ ack_inv ^ ack_glitch),
    .lnk_rx_wires(lnk_tx_wires ^ wire_mask), .lnk_rx_ack(lnk_rx_ack),
    .rx_out_vld(rx_out_vld), .rx_out_flit(rx_out_flit),
    .rx_out_rdy(rx_out_rdy), .rx_code_err(rx_code_err));

  int tests = 0, fails = 0;
  int launches = 0, errs = 0;
  logic [4:0] sym_exp [0:8191];
  logic [4:0] out_exp [0:8191];
  int sym_n = 0, sym_i = 0, out_n = 0, out_i = 0;
  logic half_v = 1'b0;
  logic [1:0] half_d = 2'd0;
  logic [6:0] prev_w = 7'd0;
  logic done = 1'b0;

  function automatic int pair_index(logic [6:0] d);
    int lo = -1, hi = -1;
    for (int b = 0; b < 7; b++) if (d[b]) begin
      if (lo < 0) lo = b;
      hi = b;
    end
    return lo * (13 - lo) / 2 + (hi - lo - 1);
  endfunction

  function automatic logic [4:0] onehot(logic [1:0] v);
    return 5'd1 << v;
  endfunction

  task automatic check(string req, logic cond, int act, int exp);
    tests++;
    if (!cond) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push_sym(logic [4:0] s);
    sym_exp[sym_n] = s;
    sym_n++;
    if (s == 5'd16) begin
      out_exp[out_n] = 5'b10000; out_n++;
    end else begin
      out_exp[out_n] = onehot(s[1:0]); out_n++;
      out_exp[out_n] = onehot(s[3:2]); out_n++;
    end
  endtask

  // expected model of R3/R4 pairing
  task automatic model_flit(logic [4:0] f);
    if (f[4]) begin
      if (half_v) push_sym({3'b000, half_d});
      half_v = 1'b0;
      push_sym(5'd16);
    end else if (!half_v) begin
      half_v = 1'b1;
      half_d = (f[0]) ? 2'd0 : (f[1]) ? 2'd1 : (f[2]) ? 2'd2 : 2'd3;
    end else begin
      push_sym({1'b0, ((f[0]) ? 2'd0 : (f[1]) ? 2'd1 : (f[2]) ? 2'd2 : 2'd3), half_d});
      half_v = 1'b0;
    end
  endtask

  task automatic send_flit(logic [4:0] f);
    @(negedge clk);
    model_flit(f);
    tx_in_vld = 1'b1;
    tx_in_flit = f;
    #1;
    while (!tx_in_rdy) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    tx_in_vld = 1'b0;
  endtask

  task automatic send_packet(int n);
    for (int k = 0; k < n; k++) send_flit(onehot(2'($urandom_range(0, 3))));
    send_flit(5'b10000);
  endtask

  task automatic drain(string req);
    int w = 0;
    while ((out_i != out_n || sym_i != sym_n) && w < 5000) begin
      @(negedge clk);
      w++;
    end
    check(req, out_i == out_n, out_i, out_n);
    check(req, sym_i == sym_n, sym_i, sym_n);
  endtask

  // monitors, sampled away from the clock edge
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      if (lnk_tx_wires != prev_w) begin
        logic [6:0] d;
        d = lnk_tx_wires ^ prev_w;
        launches++;
        // R2 / R3 / R4: decoded launch index matches the expected stream
        check("R2", $countones(d) == 2, $countones(d), 2);
        check("R3", pair_index(d) == int'(sym_exp[sym_i]), pair_index(d), int'(sym_exp[sym_i]));
        sym_i++;
      end
      prev_w = lnk_tx_wires;
      if (rx_out_vld && rx_out_rdy) begin
        // R8: output flit order
        check("R8", rx_out_flit == out_exp[out_i], int'(rx_out_flit), int'(out_exp[out_i]));
        out_i++;
      end
      if (rx_code_err) errs++;
    end
  end

  initial begin
    forever begin
      repeat ($urandom_range(20, 60)) @(negedge clk);
      if (glitch_en) begin
        ack_glitch = 1'b1;
        @(negedge clk);
        ack_glitch = 1'b0;
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (glitch_en) rx_out_rdy = ($urandom_range(0, 3) != 0);
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int l0, e0, o0;
    logic a0;
    logic stall_done;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk); #1;
    // R1
    check("R1", lnk_tx_wires == 7'd0, int'(lnk_tx_wires), 0);
    check("R1", lnk_rx_ack == 1'b0, int'(lnk_rx_ack), 0);
    check("R1", rx_out_vld == 1'b0, int'(rx_out_vld), 0);
    check("R1", tx_in_rdy == 1'b1, int'(tx_in_rdy), 1);

    // directed: even packet, odd packet (R4 pad), bare end-of-packet
    send_flit(onehot(2'd1)); send_flit(onehot(2'd2));
    send_flit(onehot(2'd3)); send_flit(onehot(2'd0)); send_flit(5'b10000);
    send_flit(onehot(2'd3)); send_flit(5'b10000);
    send_flit(5'b10000);
    drain("R4");

    // R5 / R6 / R11: consumer stalled, link must stop after two symbols
    rx_out_rdy = 1'b0;
    l0 = launches;
    stall_done = 1'b0;
    fork
      begin
        send_flit(onehot(2'd1)); send_flit(onehot(2'd2));
        send_flit(onehot(2'd3)); send_flit(onehot(2'd0));
        send_flit(onehot(2'd1)); send_flit(onehot(2'd2));
        stall_done = 1'b1;
      end
    join_none
    repeat (40) @(negedge clk);
    #3;
    check("R5", launches == l0 + 2, launches - l0, 2);
    check("R11", rx_out_vld == 1'b1, int'(rx_out_vld), 1);
    check("R11", rx_out_flit == 5'b00010, int'(rx_out_flit), 2);
    @(negedge clk) ack_glitch = 1'b1;
    @(negedge clk) ack_glitch = 1'b0;
    repeat (20) @(negedge clk);
    #3;
    check("R6", launches == l0 + 2, launches - l0, 2);
    check("R11", rx_out_flit == 5'b00010, int'(rx_out_flit), 2);
    @(negedge clk) rx_out_rdy = 1'b1;
    while (!stall_done) @(negedge clk);
    drain("R5");

    // random traffic with random backpressure and one-cycle ack pulses
    glitch_en = 1'b1;
    for (int p = 0; p < 250; p++) send_packet($urandom_range(0, 9));
    glitch_en = 1'b0;
    @(negedge clk) rx_out_rdy = 1'b1;
    drain("R6");

    // R7: persistent ack flip while idle
    repeat (10) @(negedge clk);
    l0 = launches;
    @(negedge clk) ack_inv = ~ack_inv;
    repeat (20) @(negedge clk);
    #3;
    check("R7", launches == l0, launches - l0, 0);
    send_packet(5);
    drain("R7");

    // R9: illegal pair (5,6) = index 20
    repeat (10) @(negedge clk);
    l0 = launches; e0 = errs; o0 = out_i; a0 = lnk_rx_ack;
    @(negedge clk) wire_mask = wire_mask ^ 7'b1100000;
    repeat (15) @(negedge clk);
    #3;
    check("R9", errs == e0 + 1, errs - e0, 1);
    check("R9", lnk_rx_ack != a0, int'(lnk_rx_ack), int'(!a0));
    check("R9", out_i == o0 && !rx_out_vld, out_i - o0, 0);
    check("R7", launches == l0, launches - l0, 0);

    // R10: three wires at once
    e0 = errs; a0 = lnk_rx_ack;
    @(negedge clk) wire_mask = wire_mask ^ 7'b0001011;
    repeat (15) @(negedge clk);
    #3;
    check("R10", errs == e0 + 1, errs - e0, 1);
    check("R10", lnk_rx_ack != a0, int'(lnk_rx_ack), int'(!a0));
    check("R10", out_i == o0 && !rx_out_vld, out_i - o0, 0);

    // link still works after resync
    send_packet(4);
    send_packet(3);
    drain("R10");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule